// File: doc/BRIEF.md
# Floating-Point Compare Condition Queue

This block keeps the compare-condition bits of a floating-point status register up to date after each floating-point compare. The comparator is outside the block: it delivers, together with a one-cycle valid strobe, an encoded relation between its two operands, a 5-bit condition mask, a 3-bit target selector and the exception flags the compare raised. The block folds the relation through the mask into a single true/false result. It then either writes that result into one numbered auxiliary condition bit or pushes it into a history formed by a main condition bit and an 11-entry queue behind it.

The block also tells the comparator which flavour of compare to perform. Mask bit 0 chooses a signaling compare, in which unordered operands raise invalid, or a quiet one. The exception flags of each compare are OR-ed into sticky status flags on the same clock edge that updates the condition bits. Every update lands on the rising edge that samples the valid strobe. With the strobe low, all state holds.

The update path is a small decoder that classifies each cycle as hold, targeted write or queued push. A register stage acts on that class, using one `unique case` per process.

Top module: `fcmp_cond_queue`

## Requirements
- R1: While `rst_n` is low, and after its release until the first valid compare, `cond_c`, `cond_queue`, `cond_aux` and `exc_flags` are all zero.
- R2: The result bit is taken from the mask according to the relation encoding on `cmp_rel`: 0 (greater) selects `cmp_mask[4]`, 1 (less) selects `cmp_mask[3]`, 2 (equal) selects `cmp_mask[2]` and 3 (unordered) selects `cmp_mask[1]`.
- R3: `cmp_signaling` equals `cmp_mask[0]` combinationally. A value of 1 requests a signaling compare and 0 requests a quiet one.
- R4: A valid compare with `cmp_target` = t, where t is in 1..7, writes the result bit into `cond_aux[t-1]` at the next rising edge. The other auxiliary bits, `cond_c` and `cond_queue` keep their values.
- R5: A valid compare with `cmp_target` = 0 shifts the queue by one place toward the old end. `cond_queue[i+1]` takes the previous `cond_queue[i]`, and `cond_queue[0]` (the newest entry) takes the previous `cond_c`. The previous `cond_queue[10]` is discarded.
- R6: In the same queued compare, `cond_c` takes the new result bit and `cond_aux` keeps its value.
- R7: With `cmp_valid` low, `cond_c`, `cond_queue`, `cond_aux` and `exc_flags` hold their values whatever the other inputs carry.
- R8: On every valid compare, targeted or queued, `exc_flags` becomes its previous value OR `cmp_exc` at the same edge as the condition update. The bits are sticky and are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | One-cycle strobe marking a finished compare |
| cmp_rel | input | 2 | Relation: 0 greater, 1 less, 2 equal, 3 unordered |
| cmp_mask | input | 5 | Condition mask; bits 4..1 per relation, bit 0 compare flavour |
| cmp_target | input | 3 | 0 queued push, 1..7 auxiliary bit index plus one |
| cmp_exc | input | 5 | Exception flags raised by this compare |
| cmp_signaling | output | 1 | Requests a signaling (1) or quiet (0) compare |
| cond_c | output | 1 | Main condition bit, newest queued result |
| cond_queue | output | 11 | Condition history, bit 0 newest |
| cond_aux | output | 7 | Auxiliary condition bits written by targeted compares |
| exc_flags | output | 5 | Sticky accumulated exception flags |

## Verification
The hardest case to reach from the ports is the discard at the old end of the queue. A single 1 has to travel through the main bit and all eleven queue entries, and only the cycle after the twelfth push shows it vanishing rather than wrapping or sticking. The stimulus pushes one true result and then a run of false ones, with targeted writes interleaved that must leave the queue untouched. It then covers every target index under all four relations and finishes with a long pseudo-random mix checked cycle by cycle against a behavioural model.

// File: rtl/fcq_pkg.sv
package fcq_pkg;

    localparam int MASK_W = 5;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_TARGET = 2'd1,
        OP_QUEUE  = 2'd2
    } op_e;

endpackage

// File: rtl/fcq_result_sel.sv
module fcq_result_sel
    import fcq_pkg::*;
(
    input  rel_e              rel,
    input  logic [MASK_W-1:0] mask,
    output logic              res_bit,
    output logic              signaling
);

    // R2: each relation picks its own mask bit
    always_comb begin
        unique case (rel)
            REL_GT:  res_bit = mask[4];
            REL_LT:  res_bit = mask[3];
            REL_EQ:  res_bit = mask[2];
            REL_UN:  res_bit = mask[1];
            default: res_bit = 1'b0;
        endcase
    end

    // R3: flavour request for the external comparator
    assign signaling = mask[0];

endmodule

// File: rtl/fcq_op_decode.sv
module fcq_op_decode
    import fcq_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             valid,
    input  logic [SEL_W-1:0] target,
    output op_e              op
);

    always_comb begin
        unique case ({valid, (target != '0)})
            2'b10:   op = OP_QUEUE;
            2'b11:   op = OP_TARGET;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/fcq_cond_store.sv
module fcq_cond_store
    import fcq_pkg::*;
#(
    parameter int SEL_W   = 3,
    parameter int QUEUE_W = 11,
    localparam int AUX_W  = (1 << SEL_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  op_e                op,
    input  logic [SEL_W-1:0]   target,
    input  logic               res_bit,
    output logic               c_q,
    output logic [QUEUE_W-1:0] queue_q,
    output logic [AUX_W-1:0]   aux_q
);

    logic [AUX_W-1:0] aux_we;

    genvar k;
    generate
        for (k = 0; k < AUX_W; k++) begin : g_aux_we
            assign aux_we[k] = (op == OP_TARGET) && (target == SEL_W'(k + 1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= 1'b0;
            queue_q <= '0;
            aux_q   <= '0;
        end else begin
            unique case (op)
                OP_HOLD: begin
                end
                OP_TARGET: begin
                    aux_q <= (aux_q & ~aux_we) | ({AUX_W{res_bit}} & aux_we);
                end
                OP_QUEUE: begin
                    queue_q <= {queue_q[QUEUE_W-2:0], c_q};
                    c_q     <= res_bit;
                end
                default: begin
                end
            endcase
        end
    end

    // R4: a targeted write leaves the main bit and the history alone
    a_r4_target_keeps_queue: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TARGET) |=> ($stable(c_q) && $stable(queue_q)));

    // R5: the history moves one place and takes the old main bit
    a_r5_queue_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_QUEUE) |=> ((queue_q[0] == $past(c_q)) &&
                              (queue_q[QUEUE_W-1:1] == $past(queue_q[QUEUE_W-2:0]))));

    // R6: the main bit takes the selected result; aux bits untouched
    a_r6_c_takes_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_QUEUE) |=> ((c_q == $past(res_bit)) && $stable(aux_q)));

    // R7: nothing moves on a hold cycle
    a_r7_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> ($stable(c_q) && $stable(queue_q) && $stable(aux_q)));

    // R4: at most one auxiliary bit is written per cycle
    a_r4_single_aux_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(aux_we));

endmodule

// File: rtl/fcq_flag_accum.sv
module fcq_flag_accum #(
    parameter int FLAG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [FLAG_W-1:0] exc,
    output logic [FLAG_W-1:0] flags_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (valid) begin
            flags_q <= flags_q | exc;
        end
    end

    // R8: a flag once set is never lost
    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R7: flags hold when no compare completes
    a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(flags_q));

endmodule

// File: rtl/fcmp_cond_queue.sv
module fcmp_cond_queue
    import fcq_pkg::*;
#(
    parameter int SEL_W   = 3,
    parameter int QUEUE_W = 11,
    parameter int FLAG_W  = 5,
    localparam int AUX_W  = (1 << SEL_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_valid,
    input  logic [1:0]         cmp_rel,
    input  logic [MASK_W-1:0]  cmp_mask,
    input  logic [SEL_W-1:0]   cmp_target,
    input  logic [FLAG_W-1:0]  cmp_exc,
    output logic               cmp_signaling,
    output logic               cond_c,
    output logic [QUEUE_W-1:0] cond_queue,
    output logic [AUX_W-1:0]   cond_aux,
    output logic [FLAG_W-1:0]  exc_flags
);

    logic res_bit;
    op_e  op;
    rel_e rel;

    assign rel = rel_e'(cmp_rel);

    fcq_result_sel u_sel (
        .rel       (rel),
        .mask      (cmp_mask),
        .res_bit   (res_bit),
        .signaling (cmp_signaling)
    );

    fcq_op_decode #(.SEL_W(SEL_W)) u_dec (
        .valid  (cmp_valid),
        .target (cmp_target),
        .op     (op)
    );

    fcq_cond_store #(.SEL_W(SEL_W), .QUEUE_W(QUEUE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .target  (cmp_target),
        .res_bit (res_bit),
        .c_q     (cond_c),
        .queue_q (cond_queue),
        .aux_q   (cond_aux)
    );

    fcq_flag_accum #(.FLAG_W(FLAG_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (cmp_valid),
        .exc     (cmp_exc),
        .flags_q (exc_flags)
    );

    // R3: the flavour request follows mask bit 0 at all times
    always_comb begin
        a_r3_flavour: assert (cmp_signaling == cmp_mask[0]);
    end

    // R1: state is clear on the first edge after reset release
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (!cond_c && (cond_queue == '0) && (cond_aux == '0) && (exc_flags == '0)));

endmodule

// File: tb/test_fcmp_cond_queue.sv
`timescale 1ns/1ps
module test_fcmp_cond_queue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_rel = '0;
    logic [4:0]  cmp_mask = '0;
    logic [2:0]  cmp_target = '0;
    logic [4:0]  cmp_exc = '0;
    logic        cmp_signaling;
    logic        cond_c;
    logic [10:0] cond_queue;
    logic [6:0]  cond_aux;
    logic [4:0]  exc_flags;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit        m_c;
    bit [10:0] m_q;
    bit [6:0]  m_aux;
    bit [4:0]  m_flags;
    int        lfsr = 32'h1ACE5;

    always #2.5 clk = ~clk;

    fcmp_cond_queue i_fcmp_cond_queue (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmp_valid     (cmp_valid),
        .cmp_rel       (cmp_rel),
        .cmp_mask      (cmp_mask),
        .cmp_target    (cmp_target),
        .cmp_exc       (cmp_exc),
        .cmp_signaling (cmp_signaling),
        .cond_c        (cond_c),
        .cond_queue    (cond_queue),
        .cond_aux      (cond_aux),
        .exc_flags     (exc_flags)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R2 encoding: 0 gt->bit4, 1 lt->bit3, 2 eq->bit2, 3 unordered->bit1
    function automatic bit pick(input bit [1:0] rel, input bit [4:0] mask);
        case (rel)
            2'd0: return mask[4];
            2'd1: return mask[3];
            2'd2: return mask[2];
            default: return mask[1];
        endcase
    endfunction

    task automatic compare_all();
        check(cond_c == m_c, "R6 cond_c", cond_c, m_c);
        check(cond_queue == m_q, "R5 cond_queue", cond_queue, m_q);
        check(cond_aux == m_aux, "R4 cond_aux", cond_aux, m_aux);
        check(exc_flags == m_flags, "R8 exc_flags", exc_flags, m_flags);
    endtask

    // one clock: compare the state, drive a vector, advance the model
    task automatic step(input bit v, input bit [1:0] rel, input bit [4:0] mask,
                        input bit [2:0] tgt, input bit [4:0] exc);
        bit r;
        @(negedge clk);
        compare_all();
        cmp_valid = v; cmp_rel = rel; cmp_mask = mask; cmp_target = tgt; cmp_exc = exc;
        #0.5;
        check(cmp_signaling == mask[0], "R3 cmp_signaling", cmp_signaling, mask[0]);
        r = pick(rel, mask);
        if (v) begin
            m_flags = m_flags | exc;
            if (tgt != 0) begin
                m_aux[tgt - 1] = r;
            end else begin
                m_q = {m_q[9:0], m_c};
                m_c = r;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        m_c = 0; m_q = '0; m_aux = '0; m_flags = '0;
        cmp_mask = 5'b10101;
        repeat (3) @(negedge clk);
        // R1: cleared during reset
        check({cond_c, cond_queue, cond_aux, exc_flags} == '0, "R1 reset", {cond_c, cond_queue, cond_aux, exc_flags}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({cond_c, cond_queue, cond_aux, exc_flags} == '0, "R1 after release", {cond_c, cond_queue, cond_aux, exc_flags}, 0);

        // R2: each relation with a one-hot mask into aux bits
        for (int rel = 0; rel < 4; rel++) begin
            for (int b = 1; b < 5; b++) begin
                step(1, 2'(rel), 5'(1 << b), 3'(b), 5'd0);
                step(0, 2'd0, 5'd0, 3'd0, 5'd0);
                check(cond_aux[b - 1] == (b == 4 - rel), "R2 mask select", cond_aux[b - 1], (b == 4 - rel));
            end
        end

        // R4: every target index, set then clear
        for (int t = 1; t < 8; t++) step(1, 2'd2, 5'b00100, 3'(t), 5'd0);
        for (int t = 1; t < 8; t += 2) step(1, 2'd2, 5'b11011, 3'(t), 5'd0);

        // R5/R6: single 1 walked through the whole history and dropped
        step(1, 2'd0, 5'b10000, 3'd0, 5'b00001);
        for (int i = 0; i < 13; i++) begin
            step(1, 2'd1, 5'b10000, 3'd0, 5'd0);
            if (i % 4 == 1) step(1, 2'd3, 5'b00010, 3'(1 + i % 7), 5'd0);
        end
        @(negedge clk);
        check(cond_queue == '0 && !cond_c, "R5 oldest discarded", cond_queue, 0);

        // R7: valid low with busy inputs changes nothing
        step(1, 2'd3, 5'b00011, 3'd0, 5'b00100);
        for (int i = 0; i < 5; i++) step(0, 2'(i), 5'b11111, 3'(i), 5'b11111);
        @(negedge clk);
        check(exc_flags == m_flags && cond_c == m_c, "R7 hold", exc_flags, m_flags);

        // R8: sticky flags from targeted and queued compares
        step(1, 2'd0, 5'd0, 3'd5, 5'b01000);
        step(1, 2'd0, 5'd0, 3'd0, 5'b10000);
        step(1, 2'd0, 5'd0, 3'd0, 5'b00000);

        // mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400_0000 : 0);
            step(lfsr[3] | lfsr[9], lfsr[1:0], lfsr[8:4], (lfsr[12] ? 3'd0 : lfsr[15:13]),
                 (lfsr[20:18] == 0) ? lfsr[25:21] : 5'd0);
        end
        @(negedge clk);
        compare_all();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule